// File: doc/BRIEF.md
# Quasi-Bidirectional Parallel I/O Port

This block is one parallel I/O port of a small microcontroller. Each bit has a storage latch that the CPU writes. An output buffer copies the latch onto the pad driver. A weak pullup holds the pad high whenever the bit is not pulling low, so a bit whose latch holds 1 can serve as an input. The pad can then be pulled low from outside and read back.

The CPU writes the latch with a write strobe. The strobe only takes effect in the last state of an instruction, during the second clock phase. The output buffer refreshes from the latch only in first-phase clocks, so a new value reaches the pad at the start of the next machine cycle.

Reads take one of two paths. Read-modify-write instructions see the latch contents. Plain input reads see the pad level after a synchronizer. Each bit also has an alternate output signal that can pull the pad low while the latch holds 1. The synchronized pad level is always passed to that bit's alternate input function.

Top module: `qbio_port`

## Requirements
- R1: While `rstN` is low and after it rises, every latch bit and every output buffer bit holds 1. Before any write, `rdData` with `rdSelLatch`=1 reads all ones and `pullDownEn` is all zeros.
- R2: The latch loads `wrData` only at a rising clock edge where `wrEn`, `stateSix` and `phaseTwo` are all 1. A write strobe at any other edge leaves the latch unchanged.
- R3: The output buffer copies the latch at a rising edge where `phaseOne` is 1, and holds its value at every other edge. A latch write therefore changes `pullDownEn` only after the next phase-one edge.
- R4: For each bit i, `pullDownEn[i]` is 1 unless both the buffered latch bit and `altOut[i]` are 1. `pullupOn[i]` is the inverse of `pullDownEn[i]`.
- R5: With `rdSelLatch`=1, `rdData` returns the latch contents whatever the pad level.
- R6: With `rdSelLatch`=0, `rdData` returns `pinIn` delayed by the two-flop synchronizer, so a pad change appears after the second rising edge.
- R7: `altIn` always equals the synchronized pad level, whatever the latch holds.
- R8: Writing 1 to a bit that held 0 clears that bit's `pullDownEn` after the next phase-one edge, provided `altOut` is 1. The bit is then an input again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| phaseOne | input | 1 | Current clock is a phase-one clock |
| phaseTwo | input | 1 | Current clock is a phase-two clock |
| stateSix | input | 1 | Current state is the last state of the machine cycle |
| wrEn | input | 1 | CPU write strobe for the port latch |
| wrData | input | WIDTH | Value to write into the latch |
| rdSelLatch | input | 1 | 1 selects the latch read path, 0 selects the pad read path |
| rdData | output | WIDTH | Read data for the CPU |
| altOut | input | WIDTH | Per-bit alternate output level; tie high when unused |
| altIn | output | WIDTH | Synchronized pad level for alternate input functions |
| pinIn | input | WIDTH | Level seen at the pad |
| pullDownEn | output | WIDTH | Per-bit enable for the strong pull-down driver |
| pullupOn | output | WIDTH | Per-bit flag that the weak pullup is in effect |

## Verification
A latch that captures at the wrong time shows on the latch read path after the very next edge. A buffer that samples outside phase one shows on `pullDownEn` one edge too early. Because the two delays are separated by idle cycles in the tests, an early buffer update and a late one look different. A synchronizer with the wrong depth shows on `altIn` and on the pad read path one edge early or late. Alternate-output gating errors appear at once on `pullDownEn` and `pullupOn`.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
  typedef struct packed {
    logic latchLoad;
    logic bufSample;
  } qbioStrobes_t;
endpackage

// File: rtl/qbio_ctrl.sv
module qbio_ctrl
  import qbio_pkg::*;
(
  input  logic         phaseOne,
  input  logic         phaseTwo,
  input  logic         stateSix,
  input  logic         wrEn,
  output qbioStrobes_t strobes
);
  // The latch captures only in the last state, second phase.
  // The output buffer refreshes only in phase-one clocks.
  always_comb begin
    strobes.latchLoad = wrEn & stateSix & phaseTwo;
    strobes.bufSample = phaseOne;
  end
endmodule

// File: rtl/qbio_sync.sv
module qbio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  // Stages reset to 1, the level the pullup gives an idle pad.
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) stage[s] <= '1;
        else       stage[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) stage[s] <= '1;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/qbio_datapath.sv
module qbio_datapath
  import qbio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  qbioStrobes_t     strobes,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdSelLatch,
  output logic [WIDTH-1:0] rdData,
  input  logic [WIDTH-1:0] altOut,
  output logic [WIDTH-1:0] altIn,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pullDownEn,
  output logic [WIDTH-1:0] pullupOn,
  output logic [WIDTH-1:0] latchVal,
  output logic [WIDTH-1:0] bufVal
);
  logic [WIDTH-1:0] portLatch;
  logic [WIDTH-1:0] outBuf;
  logic [WIDTH-1:0] pinSync;

  always_ff @(posedge clk) begin
    if (!rstN)                 portLatch <= '1;
    else if (strobes.latchLoad) portLatch <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 outBuf <= '1;
    else if (strobes.bufSample) outBuf <= portLatch;
  end

  qbio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (pinIn),
    .dout(pinSync)
  );

  // Per-bit driver: pull low unless buffer and alternate output are both high.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      pullDownEn[i] = ~(outBuf[i] & altOut[i]);
      pullupOn[i]   = outBuf[i] & altOut[i];
    end
  end

  assign rdData   = rdSelLatch ? portLatch : pinSync;
  assign altIn    = pinSync;
  assign latchVal = portLatch;
  assign bufVal   = outBuf;
endmodule

// File: rtl/qbio_port.sv
module qbio_port
  import qbio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseOne,
  input  logic             phaseTwo,
  input  logic             stateSix,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdSelLatch,
  output logic [WIDTH-1:0] rdData,
  input  logic [WIDTH-1:0] altOut,
  output logic [WIDTH-1:0] altIn,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pullDownEn,
  output logic [WIDTH-1:0] pullupOn
);
  qbioStrobes_t     strobes;
  logic [WIDTH-1:0] latchVal;
  logic [WIDTH-1:0] bufVal;

  qbio_ctrl u_ctrl (
    .phaseOne(phaseOne),
    .phaseTwo(phaseTwo),
    .stateSix(stateSix),
    .wrEn    (wrEn),
    .strobes (strobes)
  );

  qbio_datapath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (wrData),
    .rdSelLatch(rdSelLatch),
    .rdData    (rdData),
    .altOut    (altOut),
    .altIn     (altIn),
    .pinIn     (pinIn),
    .pullDownEn(pullDownEn),
    .pullupOn  (pullupOn),
    .latchVal  (latchVal),
    .bufVal    (bufVal)
  );
endmodule

// File: rtl/qbio_port_chk.sv
module qbio_port_chk #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             phaseOne,
  input logic             phaseTwo,
  input logic             stateSix,
  input logic             wrEn,
  input logic             rdSelLatch,
  input logic [WIDTH-1:0] rdData,
  input logic [WIDTH-1:0] altOut,
  input logic [WIDTH-1:0] altIn,
  input logic [WIDTH-1:0] pullDownEn,
  input logic [WIDTH-1:0] pullupOn,
  input logic [WIDTH-1:0] latchVal,
  input logic [WIDTH-1:0] bufVal
);
  // R1
  reset_ones_chk: assert property (@(posedge clk) !rstN |=> (latchVal == '1 && bufVal == '1));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && stateSix && phaseTwo) |=> $stable(latchVal));

  // R3
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !phaseOne |=> $stable(bufVal));

  // R3
  buf_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseOne |=> bufVal == $past(latchVal));

  // R4
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pullupOn & ~(bufVal & altOut)) == '0) && ((pullupOn ^ pullDownEn) == '1));

  // R5
  read_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdSelLatch |-> rdData == latchVal);

  // R6
  read_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdSelLatch |-> rdData == altIn);
endmodule

bind qbio_port qbio_port_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .phaseOne  (phaseOne),
  .phaseTwo  (phaseTwo),
  .stateSix  (stateSix),
  .wrEn      (wrEn),
  .rdSelLatch(rdSelLatch),
  .rdData    (rdData),
  .altOut    (altOut),
  .altIn     (altIn),
  .pullDownEn(pullDownEn),
  .pullupOn  (pullupOn),
  .latchVal  (latchVal),
  .bufVal    (bufVal)
);

// File: tb/qbio_port_bench.sv
`timescale 1ns/1ps
module qbio_port_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN;
  logic         phaseOne, phaseTwo, stateSix, wrEn, rdSelLatch;
  logic [W-1:0] wrData, altOut, pinIn;
  logic [W-1:0] rdData, altIn, pullDownEn, pullupOn;
  int           checks = 0;
  int           errors = 0;

  always #4 clk = ~clk;

  qbio_port #(.WIDTH(W), .SYNC_STAGES(2)) u_qbio_port (
    .clk(clk), .rstN(rstN), .phaseOne(phaseOne), .phaseTwo(phaseTwo),
    .stateSix(stateSix), .wrEn(wrEn), .wrData(wrData), .rdSelLatch(rdSelLatch),
    .rdData(rdData), .altOut(altOut), .altIn(altIn), .pinIn(pinIn),
    .pullDownEn(pullDownEn), .pullupOn(pullupOn)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one clock's inputs at the falling edge, then step past the rising edge.
  task automatic tick(input logic p1, input logic p2, input logic s6, input logic we, input logic [W-1:0] d);
    @(negedge clk);
    phaseOne = p1; phaseTwo = p2; stateSix = s6; wrEn = we; wrData = d;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    tick(1'b0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic writeLatch(input logic [W-1:0] d);
    tick(1'b0, 1'b1, 1'b1, 1'b1, d);
  endtask

  task automatic test_reset();
    rdSelLatch = 1'b1;
    #1;
    check("R1 latch after reset", rdData, 8'hFF);
    check("R1 pullDownEn after reset", pullDownEn, 8'h00);
    check("R4 pullupOn after reset", pullupOn, 8'hFF);
  endtask

  task automatic test_write_gating();
    tick(1'b0, 1'b1, 1'b0, 1'b1, 8'h12);  // no stateSix
    check("R2 no load without stateSix", rdData, 8'hFF);
    tick(1'b1, 1'b0, 1'b1, 1'b1, 8'h34);  // phase one, not two
    check("R2 no load in phase one", rdData, 8'hFF);
    tick(1'b0, 1'b1, 1'b1, 1'b0, 8'h56);  // no strobe
    check("R2 no load without wrEn", rdData, 8'hFF);
  endtask

  task automatic test_buffer_timing();
    writeLatch(8'h5A);
    check("R2 latch loads at S6P2", rdData, 8'h5A);
    check("R3 pad unchanged right after write", pullDownEn, 8'h00);
    idle();
    check("R3 pad unchanged in idle clock", pullDownEn, 8'h00);
    tick(1'b1, 1'b0, 1'b0, 1'b0, '0);
    check("R3 pad updates on phase one", pullDownEn, 8'hA5);
  endtask

  task automatic test_alt_out();
    @(negedge clk); altOut = 8'h0F; #1;
    check("R4 pullDownEn gated by altOut", pullDownEn, 8'hF5);
    check("R4 pullupOn gated by altOut", pullupOn, 8'h0A);
    @(negedge clk); altOut = 8'hFF; #1;
  endtask

  task automatic test_release();
    writeLatch(8'h00);
    tick(1'b1, 1'b0, 1'b0, 1'b0, '0);
    check("R8 all bits pulled low", pullDownEn, 8'hFF);
    writeLatch(8'hC3);
    tick(1'b1, 1'b0, 1'b0, 1'b0, '0);
    check("R8 written ones released", pullDownEn, 8'h3C);
    check("R8 pullup back on", pullupOn, 8'hC3);
  endtask

  task automatic test_read_paths();
    @(negedge clk); pinIn = 8'h00; rdSelLatch = 1'b1;
    idle(); idle();
    check("R5 latch path ignores pad", rdData, 8'hC3);
    @(negedge clk); rdSelLatch = 1'b0; pinIn = 8'h3C;
    @(posedge clk); #1;
    check("R6 pad path one edge late", rdData, 8'h00);
    @(posedge clk); #1;
    check("R6 pad path after two edges", rdData, 8'h3C);
    check("R7 altIn follows pad", altIn, 8'h3C);
  endtask

  task automatic test_alt_in();
    writeLatch(8'h00);
    tick(1'b1, 1'b0, 1'b0, 1'b0, '0);
    @(negedge clk); pinIn = 8'h96;
    idle(); idle();
    check("R7 altIn with latch at zero", altIn, 8'h96);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; phaseOne = 1'b0; phaseTwo = 1'b0; stateSix = 1'b0;
    wrEn = 1'b0; wrData = '0; rdSelLatch = 1'b1; altOut = 8'hFF; pinIn = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    test_reset();
    test_write_gating();
    test_buffer_timing();
    test_alt_out();
    test_release();
    test_read_paths();
    test_alt_in();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule